// File: doc/BRIEF.md
# Reconfigurable Way Data Cache

A four-way set-associative data cache whose capacity and associativity are chosen at run time from six configurations, so that software can fit the cache to each program phase. A processor load/store port issues word accesses and holds each request until the cache raises ready. A single-word backing-memory port serves line refills and write-through stores. Lines are eight 32-bit words (32 bytes).

Lowering associativity concatenates physical ways: the address bits just above the set index pick which physical way of a concatenated group holds a block, so capacity is kept while fewer ways are read per access. Ways that a configuration switches off are not flushed. They enter a retention state and keep their lines. The first access that needs a retained way spends exactly one wake-up cycle before it proceeds. Every way's tags stay live in every configuration. A store therefore invalidates a copy of the same block held in any way outside the current lookup group, so a later configuration cannot return an old value.

The controller is a three-state machine: ST_IDLE, ST_FILL and ST_WRITE. In ST_IDLE, with a request present, it does one of four things. If a retained candidate way exists, it clears retention for the candidate ways and stays in ST_IDLE, which is the wake-up stall. If the request is a store, it updates the hit way, invalidates other matching ways and takes the transition ST_IDLE→ST_WRITE. If the request is a read hit, it raises ready. If the request is a read miss, it clears the victim and takes the transition ST_IDLE→ST_FILL. ST_FILL reads the eight words of the line in order and, after the last word is acknowledged, takes ST_FILL→ST_IDLE, where the retried read now hits. ST_WRITE issues one memory write and takes ST_WRITE→ST_IDLE with ready on acknowledge.

Top module: `rwc_top`

## Requirements
- R1: After reset the active configuration code is 0 (full size, 4-way), cpu_ready and mem_req are low, and every line is invalid, so the first read misses.
- R2: A read that hits a woken way raises cpu_ready in the first request cycle with the addressed word on cpu_rdata and issues no memory access.
- R3: A read miss fetches the eight words of the line, in order, one memory read per acknowledged cycle. With a memory that acknowledges at once, the requester sees 9 stall cycles before ready, and the data returned comes from memory.
- R4: Stores are write-through. Each store issues exactly one memory write of cpu_wdata to the word address, and cpu_ready rises only on its acknowledge. A store that hits updates the cached word. A store that misses allocates nothing, so a following read of that line misses. A store without wake-up costs one stall cycle.
- R5: cfg_code values are 0 = full 4-way, 1 = full 2-way, 2 = half 2-way, 3 = full 1-way, 4 = half 1-way, 5 = quarter 1-way. A code is accepted only when cfg_valid is high, the controller is idle and cpu_req is low. An accepted code appears on cur_cfg in the next cycle. Codes 6 and 7 are ignored.
- R6: Address fields are: byte [1:0], word [4:2], set [6:5], tag [15:7]. The selector is tag bits [8:7]. In a configuration with group shift k (0, 1, 0, 2, 1, 0 for codes 0–5), logical slot j maps to physical way j·2^k + (selector mod 2^k). Two blocks that conflict at quarter size therefore both stay resident at full size in 1-way mode.
- R7: Ways disabled by a configuration keep their lines. After such a way is re-enabled, the first access whose candidate ways include it costs exactly one extra stall cycle and then hits the retained line without memory traffic.
- R8: Read-miss victims rotate round-robin over the logical slots of the current configuration. In 4-way mode a fifth distinct block in a set evicts the oldest of four, and the other three stay resident.
- R9: A store invalidates every valid copy of the same block held in any way other than the one it updates, including ways outside the current candidates and ways in retention.
- R10: cpu_ready is high only while cpu_req is high. cpu_stall is high in every cycle in which a request is pending without ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Request pending, not completing |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_code | input | 3 | Requested configuration code |
| cur_cfg | output | 3 | Active configuration code |
| mem_req | output | 1 | Backing-memory request |
| mem_we | output | 1 | Backing-memory write |
| mem_addr | output | 16 | Backing-memory byte address, word aligned |
| mem_wdata | output | 32 | Backing-memory write data |
| mem_rdata | input | 32 | Backing-memory read data |
| mem_ack | input | 1 | Backing-memory acknowledge |

## Verification
The properties assume that the processor keeps cpu_req, cpu_we, cpu_addr and cpu_wdata steady from the start of a request until the cycle after ready. They also assume that the memory returns read data in the same cycle it acknowledges. The bench drives requests at the falling edge and releases them just after the rising edge that completes them. It uses a memory model that acknowledges combinationally. It sends configuration commands only between requests, except for one deliberate attempt made while a request is pending.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE
    } rwc_state_e;

    localparam logic [2:0] CFG_LAST = 3'd5;

    // physical way holding logical slot for a group shift and selector
    function automatic logic [1:0] way_of(input logic [1:0] slot,
                                          input logic [1:0] shift,
                                          input logic [1:0] sel);
        logic [1:0] w;
        case (shift)
            2'd0:    w = slot;
            2'd1:    w = {slot[0], sel[0]};
            default: w = sel;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rwc_cfg_decode.sv
module rwc_cfg_decode (
    input  logic [2:0] code_i,
    output logic [3:0] mask_o,
    output logic [1:0] shift_o,
    output logic [1:0] amask_o
);
    always_comb begin
        case (code_i)
            3'd0:    begin mask_o = 4'b1111; shift_o = 2'd0; amask_o = 2'd3; end
            3'd1:    begin mask_o = 4'b1111; shift_o = 2'd1; amask_o = 2'd1; end
            3'd2:    begin mask_o = 4'b0011; shift_o = 2'd0; amask_o = 2'd1; end
            3'd3:    begin mask_o = 4'b1111; shift_o = 2'd2; amask_o = 2'd0; end
            3'd4:    begin mask_o = 4'b0011; shift_o = 2'd1; amask_o = 2'd0; end
            3'd5:    begin mask_o = 4'b0001; shift_o = 2'd0; amask_o = 2'd0; end
            default: begin mask_o = 4'b1111; shift_o = 2'd0; amask_o = 2'd3; end
        endcase
    end
endmodule

// File: rtl/rwc_way.sv
module rwc_way #(
    parameter int DW         = 32,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 8,
    parameter int TAGW       = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(SETS)-1:0]       set_i,
    input  logic [$clog2(LINE_WORDS)-1:0] word_i,
    input  logic [TAGW-1:0]               tag_i,
    input  logic [DW-1:0]                 data_i,
    input  logic                          data_we,
    input  logic                          tag_we,
    input  logic                          inv_i,
    output logic                          match_o,
    output logic [DW-1:0]                 rdata_o
);
    localparam int SIDX  = $clog2(SETS);
    localparam int WOFF  = $clog2(LINE_WORDS);
    localparam int DEPTH = SETS * LINE_WORDS;

    logic [TAGW-1:0] tags [SETS];
    logic [SETS-1:0] vld;
    logic [DW-1:0]   words [DEPTH];
    logic [SIDX+WOFF-1:0] widx;

    assign widx = {set_i, word_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vld <= '0;
        else if (tag_we) vld[set_i] <= 1'b1;
        else if (inv_i)  vld[set_i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (tag_we)  tags[set_i] <= tag_i;
        if (data_we) words[widx] <= data_i;
    end

    assign match_o = vld[set_i] && (tags[set_i] == tag_i);
    assign rdata_o = words[widx];
endmodule

// File: rtl/rwc_top.sv
module rwc_top
    import rwc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    output logic          cpu_stall,
    input  logic          cfg_valid,
    input  logic [2:0]    cfg_code,
    output logic [2:0]    cur_cfg,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    localparam int WAYS = 4;
    localparam int BOFF = $clog2(DW / 8);
    localparam int WOFF = $clog2(LINE_WORDS);
    localparam int SIDX = $clog2(SETS);
    localparam int TAGW = AW - BOFF - WOFF - SIDX;
    localparam logic [WOFF-1:0] LAST_WORD = WOFF'(LINE_WORDS - 1);

    rwc_state_e state, nstate;

    logic [WOFF-1:0] a_word, cnt, w_word;
    logic [SIDX-1:0] a_set;
    logic [TAGW-1:0] a_tag;
    logic [1:0]      sel;
    logic [3:0]      cur_mask;
    logic [1:0]      cur_shift, cur_amask;
    logic [WAYS-1:0] cand, match, hit_vec, hit_onehot, drowsy, inv_vec;
    logic [WAYS-1:0] data_we, tag_we, inv;
    logic [1:0]      hit_way, victim, fill_way, rr;
    logic            hit, wake_need, wake_do, fill_start, fill_wr, fill_last;
    logic            upd, write_go, cfg_accept;
    logic [DW-1:0]   w_data;
    logic [DW-1:0]   way_rdata [WAYS];

    assign a_word = cpu_addr[BOFF +: WOFF];
    assign a_set  = cpu_addr[BOFF+WOFF +: SIDX];
    assign a_tag  = cpu_addr[AW-1 -: TAGW];
    assign sel    = a_tag[1:0];

    rwc_cfg_decode u_dec (
        .code_i  (cur_cfg),
        .mask_o  (cur_mask),
        .shift_o (cur_shift),
        .amask_o (cur_amask)
    );

    always_comb begin
        cand = '0;
        for (int j = 0; j < WAYS; j++) begin
            if (2'(j) <= cur_amask) cand[way_of(2'(j), cur_shift, sel)] = 1'b1;
        end
        cand = cand & cur_mask;
    end

    assign victim    = way_of(rr & cur_amask, cur_shift, sel);
    assign hit_vec   = match & cand;
    assign hit       = |hit_vec;
    assign wake_need = |(cand & drowsy);

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = 2'(w);
        end
    end

    assign hit_onehot = hit ? (WAYS'(1) << hit_way) : '0;
    assign w_word     = (state == ST_FILL) ? cnt : a_word;
    assign w_data     = (state == ST_FILL) ? mem_rdata : cpu_wdata;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            data_we[w] = (fill_wr && fill_way == 2'(w)) || (upd && hit_way == 2'(w));
            tag_we[w]  = fill_last && fill_way == 2'(w);
            inv[w]     = (fill_start && victim == 2'(w)) || inv_vec[w];
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        rwc_way #(
            .DW(DW), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .TAGW(TAGW)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (a_set),
            .word_i  (w_word),
            .tag_i   (a_tag),
            .data_i  (w_data),
            .data_we (data_we[g]),
            .tag_we  (tag_we[g]),
            .inv_i   (inv[g]),
            .match_o (match[g]),
            .rdata_o (way_rdata[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // next state and outputs
    always_comb begin
        nstate     = state;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        wake_do    = 1'b0;
        fill_start = 1'b0;
        fill_wr    = 1'b0;
        fill_last  = 1'b0;
        upd        = 1'b0;
        write_go   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (wake_need) begin
                        wake_do = 1'b1;
                    end else if (cpu_we) begin
                        write_go = 1'b1;
                        upd      = hit;
                        nstate   = ST_WRITE;
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        fill_start = 1'b1;
                        nstate     = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_wr = 1'b1;
                    if (cnt == LAST_WORD) begin
                        fill_last = 1'b1;
                        nstate    = ST_IDLE;
                    end
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    nstate    = ST_IDLE;
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    assign inv_vec    = write_go ? (match & ~hit_onehot) : '0;
    assign cfg_accept = (state == ST_IDLE) && !cpu_req && cfg_valid && (cfg_code <= CFG_LAST);
    assign cpu_stall  = cpu_req && !cpu_ready;
    assign cpu_rdata  = way_rdata[hit_way];
    assign mem_wdata  = cpu_wdata;
    assign mem_addr   = (state == ST_FILL) ? {a_tag, a_set, cnt, {BOFF{1'b0}}}
                                           : {cpu_addr[AW-1:BOFF], {BOFF{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            fill_way <= '0;
            rr       <= '0;
            drowsy   <= '0;
            cur_cfg  <= '0;
        end else begin
            if (fill_start) begin
                cnt      <= '0;
                fill_way <= victim;
                rr       <= rr + 2'd1;
            end else if (fill_wr) begin
                cnt <= cnt + 1'b1;
            end
            drowsy <= (drowsy & ~(wake_do ? cand : '0)) | ~cur_mask;
            if (cfg_accept) cur_cfg <= cfg_code;
        end
    end
endmodule

// File: rtl/rwc_checker.sv
module rwc_checker #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [DW-1:0] cpu_wdata,
    input logic          cpu_ready,
    input logic          cfg_valid,
    input logic [2:0]    cur_cfg,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr
);
    a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    a_r2_read_done_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_we) |-> !mem_req);

    a_r4_write_through_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (cpu_req && cpu_we && mem_wdata == cpu_wdata));

    a_r4_write_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ack));

    a_r3_fill_only_for_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (cpu_req && !cpu_we));

    a_r5_cfg_change_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cfg != $past(cur_cfg)) |-> ($past(cfg_valid) && !$past(cpu_req)));

    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cur_cfg <= 3'd5);

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind rwc_top rwc_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cfg_valid (cfg_valid),
    .cur_cfg   (cur_cfg),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/tb_rwc_top.sv
`timescale 1ns/100ps
module tb_rwc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic        cpu_ready, cpu_stall;
    logic        cfg_valid = 1'b0;
    logic [2:0]  cfg_code = '0, cur_cfg;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    logic [31:0] bmem [16384];
    int n_rd = 0, n_wr = 0;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rwc_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .cpu_stall(cpu_stall), .cfg_valid(cfg_valid),
        .cfg_code(cfg_code), .cur_cfg(cur_cfg), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = bmem[mem_addr[15:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            bmem[mem_addr[15:2]] <= mem_wdata;
            n_wr <= n_wr + 1;
        end else if (mem_req) begin
            n_rd <= n_rd + 1;
        end
    end

    function automatic logic [15:0] mk(input int tag, input int set, input int word);
        return {9'(tag), 2'(set), 3'(word), 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int st, output int nr, output int nw);
        int r0, w0, guard;
        bit stall_ok;
        r0 = n_rd; w0 = n_wr; st = 0; guard = 0; stall_ok = 1;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        #1;
        while (!cpu_ready && guard < 60) begin
            if (!cpu_stall) stall_ok = 0;
            st++;
            guard++;
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        if (!stall_ok) chk("R10 stall during wait", 0, 1);
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        nr = n_rd - r0; nw = n_wr - w0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] addr, input int exp_st, input int exp_nr);
        logic [31:0] d; int st, nr, nw;
        access(1'b0, addr, 32'h0, d, st, nr, nw);
        chk({req, " stalls"}, st, exp_st);
        chk({req, " mem reads"}, nr, exp_nr);
        chk({req, " data"}, d, bmem[addr[15:2]]);
    endtask

    task automatic wr_chk(input string req, input logic [15:0] addr, input logic [31:0] v, input int exp_st);
        logic [31:0] d; int st, nr, nw;
        access(1'b1, addr, v, d, st, nr, nw);
        chk({req, " write stalls"}, st, exp_st);
        chk({req, " mem writes"}, nw, 1);
        chk({req, " memory word"}, bmem[addr[15:2]], v);
    endtask

    task automatic set_cfg(input logic [2:0] code, input logic [2:0] exp, input string req);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_code = code;
        @(negedge clk);
        cfg_valid = 1'b0;
        #1;
        chk({req, " cur_cfg"}, 32'(cur_cfg), 32'(exp));
    endtask

    task automatic t_reset;
        #1;
        chk("R1 reset cfg", 32'(cur_cfg), 0);
        chk("R1 reset ready", 32'(cpu_ready), 0);
        chk("R1 reset mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_read;
        rd_chk("R1 R3 first read miss", mk(1, 0, 3), 9, 8);
        rd_chk("R2 read hit", mk(1, 0, 5), 0, 0);
    endtask

    task automatic t_write;
        wr_chk("R4 write hit", mk(1, 0, 3), 32'hCAFE0001, 1);
        rd_chk("R4 updated word", mk(1, 0, 3), 0, 0);
        wr_chk("R4 write miss", mk(2, 1, 0), 32'hCAFE0002, 1);
        rd_chk("R4 no allocate", mk(2, 1, 0), 9, 8);
    endtask

    task automatic t_rr;
        for (int t = 10; t < 14; t++) rd_chk("R8 fill", mk(t, 2, 1), 9, 8);
        for (int t = 10; t < 14; t++) rd_chk("R8 four resident", mk(t, 2, 1), 0, 0);
        rd_chk("R8 fifth block", mk(14, 2, 1), 9, 8);
        rd_chk("R8 oldest evicted", mk(10, 2, 1), 9, 8);
        rd_chk("R8 newer kept", mk(13, 2, 1), 0, 0);
    endtask

    task automatic t_config;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(13, 2, 1);
        cfg_valid = 1'b1; cfg_code = 3'd5;
        #1;
        chk("R5 hit during cfg attempt", 32'(cpu_ready), 1);
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cfg_valid = 1'b0;
        @(negedge clk);
        #1;
        chk("R5 cfg ignored while request", 32'(cur_cfg), 0);
        set_cfg(3'd7, 3'd0, "R5 illegal code ignored");
        set_cfg(3'd2, 3'd2, "R5 legal code accepted");
        set_cfg(3'd0, 3'd0, "R5 back to full");
    endtask

    task automatic t_retention;
        set_cfg(3'd5, 3'd5, "R7 quarter");
        rd_chk("R7 quarter fill", mk(20, 3, 0), 9, 8);
        set_cfg(3'd0, 3'd0, "R7 full again");
        rd_chk("R7 retained hit after wake", mk(13, 2, 1), 1, 0);
        rd_chk("R7 no second wake", mk(12, 2, 1), 0, 0);
    endtask

    task automatic t_concat;
        set_cfg(3'd5, 3'd5, "R6 quarter");
        rd_chk("R6 quarter A", mk(32, 1, 0), 9, 8);
        rd_chk("R6 quarter B", mk(33, 1, 0), 9, 8);
        rd_chk("R6 quarter conflict", mk(32, 1, 0), 9, 8);
        set_cfg(3'd3, 3'd3, "R6 full 1-way");
        rd_chk("R6 A in way0", mk(32, 1, 0), 0, 0);
        rd_chk("R6 B wake and miss", mk(33, 1, 0), 10, 8);
        rd_chk("R6 A still resident", mk(32, 1, 0), 0, 0);
        rd_chk("R6 B resident", mk(33, 1, 0), 0, 0);
    endtask

    task automatic t_inval;
        set_cfg(3'd5, 3'd5, "R9 quarter");
        rd_chk("R9 copy in way0", mk(41, 0, 2), 9, 8);
        set_cfg(3'd3, 3'd3, "R9 full 1-way");
        wr_chk("R9 write other mapping", mk(41, 0, 2), 32'hBEEF0009, 2);
        set_cfg(3'd5, 3'd5, "R9 quarter again");
        rd_chk("R9 stale copy invalidated", mk(41, 0, 2), 9, 8);
    endtask

    initial begin
        for (int i = 0; i < 16384; i++) bmem[i] = (i * 32'h9E3779B1) + 32'h1357;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read();
        t_write();
        t_rr();
        t_config();
        t_retention();
        t_concat();
        t_inval();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule